// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column addresses of one memory data burst in the order in which the data elements are transferred. A controller pulses `start_i` and supplies three things: the column address where the burst begins, a code for the burst length (2, 4 or 8 elements) and the access order (sequential or interleaved). Starting on the next clock, the block emits one column address per cycle with `valid_o` high. It raises `last_o` on the final element.

Each burst stays inside an aligned block of columns whose size equals the burst length. Only the low column bits that select an element within that block change, and every bit above them keeps the value of the starting address. In sequential order the low bits count up from the start and wrap back to the beginning of the block. In interleaved order the low bits are the start offset XOR the beat number.

A new start is taken only while the block is idle or on the final beat of the current burst. When a start arrives on the final beat, the next burst follows with no idle cycle. An unsupported length code runs as a 2-element burst and reports an error pulse.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, `valid_o`, `last_o` and `len_err_o` are all low.
- R2: Length code 2'd1 gives 2 beats, 2'd2 gives 4 beats and 2'd3 gives 8 beats. `last_o` is high on the final beat only, and `valid_o` is low on the cycle after that beat unless a new start was taken.
- R3: With `order_i` = 0 (sequential), beat k carries the low offset (s + k) mod N, where s is the start's low offset and N is the burst length. For example, start 5 at N = 8 gives 5,6,7,0,1,2,3,4.
- R4: With `order_i` = 1 (interleaved), beat k carries the low offset s XOR k. For example, start 5 at N = 8 gives 5,4,7,6,1,0,3,2, and start 2 at N = 4 gives 2,3,0,1.
- R5: Every column bit at or above bit log2(N) equals the corresponding bit of the start address on every beat of the burst.
- R6: For a 2-beat burst, both orders give the same sequence: the start column, then the start column with bit 0 inverted.
- R7: A start that arrives while a burst is active and not on its final beat is ignored. The current burst continues unchanged.
- R8: A start on the final beat is accepted, and its first beat appears on the very next cycle.
- R9: Length code 2'd0 runs a 2-beat burst. `len_err_o` is high for exactly one cycle, on the first beat of that burst.
- R10: The first beat appears on the cycle after the accepting clock edge, and the beats that follow come one per clock with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin a burst |
| col_i | input | COL_W | Starting column address |
| blen_i | input | 2 | Length code: 1 = 2 beats, 2 = 4 beats, 3 = 8 beats, 0 = unsupported |
| order_i | input | 1 | 0 = sequential, 1 = interleaved |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | The current beat is the final one of its burst |
| len_err_o | output | 1 | One-cycle pulse on the first beat of a burst started with an unsupported code |

## Verification
The assertions assume that the inputs are stable across each rising clock edge, and that `start_i` is treated as meaningful only when it is sampled at that edge. A start that arrives at any other time during a burst is expected to be dropped, not queued. The bench meets this by changing every input on the falling edge only. It holds `start_i` for exactly one cycle per request, except where it deliberately pulses a start in the middle of a burst or on the final beat to exercise the ignore and back-to-back cases.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
    localparam int OFF_W = 3;

    typedef logic [OFF_W-1:0] off_t;

    typedef enum logic [1:0] {
        BL_BAD = 2'd0,
        BL_2   = 2'd1,
        BL_4   = 2'd2,
        BL_8   = 2'd3
    } blen_e;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_XOR = 1'b1
    } order_e;
endpackage

// File: rtl/bcs_len_decode.sv
module bcs_len_decode
    import bcs_pkg::*;
(
    input  logic [1:0] code_i,
    output off_t       mask_o,
    output logic       bad_o
);
    always_comb begin
        mask_o = off_t'(1);
        bad_o  = 1'b0;
        case (blen_e'(code_i))
            BL_2:    mask_o = off_t'(1);
            BL_4:    mask_o = off_t'(3);
            BL_8:    mask_o = off_t'(7);
            default: bad_o  = 1'b1;
        endcase
    end
endmodule

// File: rtl/bcs_order_gen.sv
module bcs_order_gen
    import bcs_pkg::*;
(
    input  off_t start_off_i,
    input  off_t beat_i,
    input  off_t mask_i,
    input  logic xor_mode_i,
    output off_t off_o
);
    off_t sum_w;
    assign sum_w = start_off_i + beat_i;

    for (genvar b = 0; b < OFF_W; b++) begin : g_bit
        assign off_o[b] = mask_i[b] &
            (xor_mode_i ? (start_off_i[b] ^ beat_i[b]) : sum_w[b]);
    end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] col_i,
    input  logic [1:0]       blen_i,
    input  logic             order_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o,
    output logic             len_err_o
);
    localparam int HI_W = COL_W - OFF_W;

    typedef struct packed {
        logic             active;
        logic [COL_W-1:0] base;
        off_t             mask;
        off_t             beat;
        logic             xor_mode;
        logic             err;
    } state_t;

    state_t s_d, s_q;
    off_t   dec_mask_w;
    logic   dec_bad_w;
    off_t   start_off_w;
    off_t   off_w;
    logic   last_w;
    logic   accept_w;

    bcs_len_decode u_dec (
        .code_i (blen_i),
        .mask_o (dec_mask_w),
        .bad_o  (dec_bad_w)
    );

    assign start_off_w = s_q.base[OFF_W-1:0] & s_q.mask;

    bcs_order_gen u_ord (
        .start_off_i (start_off_w),
        .beat_i      (s_q.beat),
        .mask_i      (s_q.mask),
        .xor_mode_i  (s_q.xor_mode),
        .off_o       (off_w)
    );

    assign last_w   = s_q.active && (s_q.beat == s_q.mask);
    assign accept_w = start_i && (!s_q.active || last_w);

    always_comb begin
        s_d     = s_q;
        s_d.err = 1'b0;
        if (accept_w) begin
            s_d.active   = 1'b1;
            s_d.base     = col_i;
            s_d.mask     = dec_mask_w;
            s_d.beat     = '0;
            s_d.xor_mode = (order_e'(order_i) == ORD_XOR);
            s_d.err      = dec_bad_w;
        end else if (s_q.active) begin
            if (last_w) begin
                s_d.active = 1'b0;
            end else begin
                s_d.beat = s_q.beat + off_t'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign col_o     = {s_q.base[COL_W-1:OFF_W],
                        (s_q.base[OFF_W-1:0] & ~s_q.mask) | off_w};
    assign valid_o   = s_q.active;
    assign last_o    = last_w;
    assign len_err_o = s_q.err;

    // R10
    no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !last_o |=> valid_o);

    // R2
    burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o && !start_i |=> !valid_o);

    // R8
    back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o && start_i |=> valid_o);

    // R5
    upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !last_o |=> $stable(col_o[COL_W-1:OFF_W]));

    // R7
    ignore_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !last_o && start_i |=> $stable(s_q.base));

    // R9
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        len_err_o |=> !len_err_o);

    // R9
    err_first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        len_err_o |-> valid_o && !last_o);

    // R2
    last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    initial begin
        assert (HI_W >= 0) else $error("column width below block offset width");
    end
endmodule

// File: tb/burst_col_seq_tb_top.sv
module burst_col_seq_tb_top;
    localparam int COL_W = 10;
    localparam int NV    = 9;

    typedef struct packed {
        logic [9:0]      col;
        logic [1:0]      blen;
        logic            ord;
        logic [3:0]      n;
        logic [0:7][9:0] exp;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{col:10'h2A5, blen:2'd3, ord:1'b0, n:4'd8,
          exp:'{10'h2A5,10'h2A6,10'h2A7,10'h2A0,10'h2A1,10'h2A2,10'h2A3,10'h2A4}},
        '{col:10'h2A5, blen:2'd3, ord:1'b1, n:4'd8,
          exp:'{10'h2A5,10'h2A4,10'h2A7,10'h2A6,10'h2A1,10'h2A0,10'h2A3,10'h2A2}},
        '{col:10'h012, blen:2'd2, ord:1'b1, n:4'd4,
          exp:'{10'h012,10'h013,10'h010,10'h011,10'h0,10'h0,10'h0,10'h0}},
        '{col:10'h3F1, blen:2'd2, ord:1'b0, n:4'd4,
          exp:'{10'h3F1,10'h3F2,10'h3F3,10'h3F0,10'h0,10'h0,10'h0,10'h0}},
        '{col:10'h3F1, blen:2'd2, ord:1'b1, n:4'd4,
          exp:'{10'h3F1,10'h3F0,10'h3F3,10'h3F2,10'h0,10'h0,10'h0,10'h0}},
        '{col:10'h155, blen:2'd1, ord:1'b0, n:4'd2,
          exp:'{10'h155,10'h154,10'h0,10'h0,10'h0,10'h0,10'h0,10'h0}},
        '{col:10'h155, blen:2'd1, ord:1'b1, n:4'd2,
          exp:'{10'h155,10'h154,10'h0,10'h0,10'h0,10'h0,10'h0,10'h0}},
        '{col:10'h0FB, blen:2'd3, ord:1'b1, n:4'd8,
          exp:'{10'h0FB,10'h0FA,10'h0F9,10'h0F8,10'h0FF,10'h0FE,10'h0FD,10'h0FC}},
        '{col:10'h0FE, blen:2'd3, ord:1'b0, n:4'd8,
          exp:'{10'h0FE,10'h0FF,10'h0F8,10'h0F9,10'h0FA,10'h0FB,10'h0FC,10'h0FD}}
    };

    localparam string TAG [NV] = '{"R3/R5", "R4/R5", "R4", "R3/R5", "R4",
                                   "R6", "R6", "R4/R5", "R3"};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] col_i = '0;
    logic [1:0]       blen_i = 2'd1;
    logic             order_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             valid_o;
    logic             last_o;
    logic             len_err_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    burst_col_seq #(.COL_W(COL_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .col_i     (col_i),
        .blen_i    (blen_i),
        .order_i   (order_i),
        .col_o     (col_o),
        .valid_o   (valid_o),
        .last_o    (last_o),
        .len_err_o (len_err_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic launch(input logic [9:0] c, input logic [1:0] b, input logic o);
        @(negedge clk);
        start_i = 1'b1;
        col_i   = c;
        blen_i  = b;
        order_i = o;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    initial begin
        #2000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs idle during and right after reset
        chk(!valid_o && !last_o && !len_err_o, "R1",
            {valid_o, last_o, len_err_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!valid_o && !last_o && !len_err_o, "R1",
            {valid_o, last_o, len_err_o}, 0);

        // Table walk: R2 beat count/last, R3/R4 order, R5 upper bits, R6, R10
        for (int v = 0; v < NV; v++) begin
            launch(VEC[v].col, VEC[v].blen, VEC[v].ord);
            for (int i = 0; i < int'(VEC[v].n); i++) begin
                chk(valid_o == 1'b1, "R10", valid_o, 1);
                chk(col_o == VEC[v].exp[i], TAG[v], col_o, VEC[v].exp[i]);
                chk(last_o == (i == int'(VEC[v].n) - 1), "R2", last_o,
                    (i == int'(VEC[v].n) - 1));
                chk(!len_err_o, "R9", len_err_o, 0);
                @(negedge clk);
            end
            chk(!valid_o, "R2", valid_o, 0);
        end

        // R9: unsupported code runs two beats, error on first beat only
        launch(10'h0A3, 2'd0, 1'b0);
        chk(valid_o && col_o == 10'h0A3, "R9", col_o, 10'h0A3);
        chk(len_err_o == 1'b1, "R9", len_err_o, 1);
        @(negedge clk);
        chk(valid_o && last_o && col_o == 10'h0A2, "R9", col_o, 10'h0A2);
        chk(len_err_o == 1'b0, "R9", len_err_o, 0);
        @(negedge clk);
        chk(!valid_o, "R9", valid_o, 0);

        // R7: start in mid-burst is ignored
        launch(10'h000, 2'd3, 1'b0);
        for (int i = 0; i < 8; i++) begin
            if (i == 2) begin
                start_i = 1'b1;
                col_i   = 10'h3FF;
                blen_i  = 2'd1;
                order_i = 1'b1;
            end else begin
                start_i = 1'b0;
            end
            chk(valid_o && col_o == 10'(i), "R7", col_o, i);
            @(negedge clk);
        end
        start_i = 1'b0;
        chk(!valid_o, "R7", valid_o, 0);

        // R8: start on final beat follows with no gap
        launch(10'h100, 2'd1, 1'b0);
        chk(col_o == 10'h100 && !last_o, "R8", col_o, 10'h100);
        @(negedge clk);
        chk(last_o && col_o == 10'h101, "R8", col_o, 10'h101);
        start_i = 1'b1;
        col_i   = 10'h205;
        blen_i  = 2'd2;
        order_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        chk(valid_o && col_o == 10'h205, "R8", col_o, 10'h205);
        @(negedge clk);
        chk(col_o == 10'h206, "R8", col_o, 10'h206);
        @(negedge clk);
        chk(col_o == 10'h207, "R8", col_o, 10'h207);
        @(negedge clk);
        chk(col_o == 10'h204 && last_o, "R8", col_o, 10'h204);
        @(negedge clk);
        chk(!valid_o, "R8", valid_o, 0);

        report();
    end
endmodule